// File: doc/BRIEF.md
# Strobed Parallel Register Port with Read-Back

This block lets a host reach a small internal register file over an 8-bit bus that it shares with a converter's live output samples. Every transaction starts with a low pulse on an active-low strobe. Two mode pins qualify each pulse. A read-not-write pin and a data-not-address pin, both low, mark an address cycle. Data-not-address high with read-not-write low marks a write-data cycle. Both high mark a read cycle. The block samples the bus value on the strobe's falling edge. All pins pass through two-flop synchronisers into the system clock domain, so the strobe must stay low for at least three clock periods.

Read-back takes two steps. The host first strobes in an address with bit 4 set, which arms the read. A later read strobe then puts the register at that address, with bit 4 cleared, onto the bus. While the host drives the bus, the block releases it. Otherwise the block drives either the live sample word or the read-back byte, and only while output-enable is low. A parameter sets when the port goes back to sample data after a read: on the strobe's rising edge, or on the next strobe's falling edge.

Top module: `strobed_regport`

## Requirements
- R1: After reset, with output-enable low and no strobe, bus_oe is 1 and bus_out equals sample_in.
- R2: A strobe falling edge with rnw=0 and dna=0 captures bus_in[5:0] as the current address. Bit 4 of that address selects read-arming.
- R3: A strobe falling edge with rnw=0 and dna=1 stores bus_in into the register at the current address, when address bit 4 is 0.
- R4: When the current address has bit 4 set, a write-data strobe changes no register. That address arms read-back.
- R5: A strobe falling edge with rnw=1 and dna=1, while armed, drives the register at the armed address with bit 4 cleared onto bus_out, with register bit 0 on bus_out[0].
- R6: Outside read-back, bus_out follows sample_in live, cycle by cycle.
- R7: While the strobe is low with rnw=0, bus_oe is 0. After the strobe rises, bus_oe returns to 1.
- R8: While oe_n is high, bus_oe is 0, including during read-back.
- R9: With RET_ON_RISE=1, the port returns to sample data when the read strobe rises. With RET_ON_RISE=0, read data stays on the bus until the next strobe falling edge.
- R10: A read strobe that arrives while not armed has no effect: bus_out stays on sample data.
- R11: A strobe with rnw=1 and dna=0 changes neither the address nor the arming, and it does not release the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strobe_n | input | 1 | Active-low transaction strobe |
| rnw | input | 1 | Read-not-write mode pin |
| dna | input | 1 | Data-not-address mode pin |
| oe_n | input | 1 | Active-low output enable |
| bus_in | input | 8 | Bus value driven by the host |
| sample_in | input | 8 | Live converter sample word |
| bus_out | output | 8 | Value the block drives on the bus |
| bus_oe | output | 1 | Bus drive enable (0 = high impedance) |

## Verification
The bench builds two copies that receive the same pin activity. One uses the default RET_ON_RISE=1. The other uses RET_ON_RISE=0, so both return-to-sample policies are compared against each other during the same read sequences. The default 6-bit address and bit-4 flag let the bench reach registers above and below the flag bit, for example 0x05 and 0x25. It can also show that a flagged write leaves its cleared-flag partner register untouched. An asymmetric data pattern confirms the bit order on the bus.

// File: rtl/srp_pkg.sv
package srp_pkg;

  typedef enum logic [1:0] {
    OP_ADDR   = 2'd0,
    OP_WDATA  = 2'd1,
    OP_IGNORE = 2'd2,
    OP_READ   = 2'd3
  } srp_op_e;

  // Mode pins -> strobe meaning
  function automatic srp_op_e srp_decode(input logic rnw, input logic dna);
    case ({rnw, dna})
      2'b00:   return OP_ADDR;
      2'b01:   return OP_WDATA;
      2'b11:   return OP_READ;
      default: return OP_IGNORE;
    endcase
  endfunction

endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/srp_regfile.sv
module srp_regfile #(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 8,
  parameter int FLAG_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem[rd_addr];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(wr_addr)] == $past(wr_data)); // R3
  AST_FLAG_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !wr_addr[FLAG_BIT]); // R4
endmodule

// File: rtl/srp_seq.sv
module srp_seq
  import srp_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 8,
  parameter int FLAG_BIT    = 4,
  parameter bit RET_ON_RISE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strb_n_s,
  input  logic              rnw_s,
  input  logic              dna_s,
  input  logic [DATA_W-1:0] bus_s,
  input  logic [DATA_W-1:0] rf_rd_data,
  output logic [ADDR_W-1:0] rf_rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              host_phase,
  output logic              show_rd,
  output logic [DATA_W-1:0] rd_data
);
  // Address register with the flag bit removed
  function automatic logic [ADDR_W-1:0] target_of(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] m;
    m = '1;
    m[FLAG_BIT] = 1'b0;
    return a & m;
  endfunction

  logic              strb_d;
  logic              strb_fall;
  logic              strb_rise;
  srp_op_e           op;
  logic              addr_evt;
  logic              rd_evt;
  logic              leave_evt;
  logic [ADDR_W-1:0] addr_q;
  logic              armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strb_d <= 1'b1;
    else        strb_d <= strb_n_s;
  end

  assign strb_fall  = strb_d & ~strb_n_s;
  assign strb_rise  = ~strb_d & strb_n_s;
  assign op         = srp_decode(rnw_s, dna_s);
  assign addr_evt   = strb_fall && (op == OP_ADDR);
  assign wr_en      = strb_fall && (op == OP_WDATA) && !addr_q[FLAG_BIT];
  assign rd_evt     = strb_fall && (op == OP_READ) && armed;
  assign host_phase = ~strb_n_s & ~rnw_s;
  assign wr_addr    = addr_q;
  assign wr_data    = bus_s;
  assign rf_rd_addr = target_of(addr_q);

  generate
    if (RET_ON_RISE) begin : g_ret_rise
      assign leave_evt = strb_rise;
    end else begin : g_ret_next
      assign leave_evt = strb_fall;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      armed  <= 1'b0;
    end else if (addr_evt) begin
      addr_q <= bus_s[ADDR_W-1:0];
      armed  <= bus_s[FLAG_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      show_rd <= 1'b0;
      rd_data <= '0;
    end else if (rd_evt) begin
      show_rd <= 1'b1;
      rd_data <= rf_rd_data;
    end else if (leave_evt) begin
      show_rd <= 1'b0;
    end
  end

  AST_READ_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_evt |=> show_rd && (rd_data == $past(rf_rd_data))); // R5
  AST_ARM_FOLLOWS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    addr_evt |=> armed == $past(bus_s[FLAG_BIT])); // R4
  AST_UNARMED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_fall && op == OP_READ && !armed && !show_rd) |=> !show_rd); // R10
  AST_IGNORED_KEEPS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_fall && op == OP_IGNORE) |=> $stable(addr_q) && $stable(armed)); // R11
  AST_RETURN_POLICY: assert property (@(posedge clk) disable iff (!rst_n)
    (leave_evt && !rd_evt) |=> !show_rd); // R9
endmodule

// File: rtl/strobed_regport.sv
module strobed_regport #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 8,
  parameter int FLAG_BIT    = 4,
  parameter bit RET_ON_RISE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_n,
  input  logic              rnw,
  input  logic              dna,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] bus_in,
  input  logic [DATA_W-1:0] sample_in,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe
);
  localparam int CTL_W = 4;

  logic [CTL_W-1:0]  ctl_s;
  logic [DATA_W-1:0] bus_s;
  logic              strb_n_s;
  logic              oe_n_s;
  logic              rnw_s;
  logic              dna_s;
  logic [ADDR_W-1:0] rf_rd_addr;
  logic [DATA_W-1:0] rf_rd_data;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              host_phase;
  logic              show_rd;
  logic [DATA_W-1:0] rd_data;

  srp_sync #(.W(CTL_W), .RST_VAL(4'b1100)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n),
    .d({strobe_n, oe_n, rnw, dna}), .q(ctl_s)
  );

  srp_sync #(.W(DATA_W), .RST_VAL('0)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_in), .q(bus_s)
  );

  assign {strb_n_s, oe_n_s, rnw_s, dna_s} = ctl_s;

  srp_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FLAG_BIT(FLAG_BIT), .RET_ON_RISE(RET_ON_RISE)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .strb_n_s(strb_n_s), .rnw_s(rnw_s), .dna_s(dna_s), .bus_s(bus_s),
    .rf_rd_data(rf_rd_data), .rf_rd_addr(rf_rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .host_phase(host_phase), .show_rd(show_rd), .rd_data(rd_data)
  );

  srp_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FLAG_BIT(FLAG_BIT)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rf_rd_addr), .rd_data(rf_rd_data)
  );

  assign bus_oe  = ~oe_n_s & ~host_phase;
  assign bus_out = show_rd ? rd_data : sample_in;

  AST_HOST_GETS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || (!strb_n_s && !rnw_s)) |-> !bus_oe); // R7
  AST_NO_WRITE_DURING_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (show_rd && $past(show_rd)) |-> $stable(bus_out)); // R5
endmodule

// File: tb/strobed_regport_tb.sv
module strobed_regport_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strobe_n = 1'b1;
  logic       rnw = 1'b0;
  logic       dna = 1'b0;
  logic       oe_n = 1'b0;
  logic [7:0] bus_in = 8'h00;
  logic [7:0] sample_in = 8'h77;
  logic [7:0] out_a, out_b;
  logic       oe_a, oe_b;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    int         unit;
    logic       oe;
    logic [7:0] d;
    string      req;
  } item_t;

  item_t sb[$];

  always #10 clk = ~clk;

  strobed_regport dut_i (
    .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .rnw(rnw), .dna(dna),
    .oe_n(oe_n), .bus_in(bus_in), .sample_in(sample_in),
    .bus_out(out_a), .bus_oe(oe_a)
  );

  strobed_regport #(.RET_ON_RISE(1'b0)) dut_hold_i (
    .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .rnw(rnw), .dna(dna),
    .oe_n(oe_n), .bus_in(bus_in), .sample_in(sample_in),
    .bus_out(out_b), .bus_oe(oe_b)
  );

  // Monitor: pops expectations and compares at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        item_t it;
        logic       a_oe;
        logic [7:0] a_d;
        it = sb.pop_front();
        a_oe = (it.unit == 0) ? oe_a : oe_b;
        a_d  = (it.unit == 0) ? out_a : out_b;
        total++;
        if (a_oe !== it.oe || (it.oe && a_d !== it.d)) begin
          bad++;
          $display("FAIL %s unit%0d: oe=%b data=%h, expected oe=%b data=%h",
                   it.req, it.unit, a_oe, a_d, it.oe, it.d);
        end
      end
    end
  end

  task automatic expect_both(input logic oe0, input logic [7:0] d0,
                             input logic oe1, input logic [7:0] d1,
                             input string req);
    item_t it;
    #1;
    it.unit = 0; it.oe = oe0; it.d = d0; it.req = req; sb.push_back(it);
    it.unit = 1; it.oe = oe1; it.d = d1; it.req = req; sb.push_back(it);
    wait (sb.size() == 0);
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic strobe_lo(input logic r, input logic d, input logic [7:0] v);
    @(negedge clk);
    rnw = r; dna = d; bus_in = v;
    @(negedge clk);
    strobe_n = 1'b0;
    settle();
  endtask

  task automatic strobe_hi();
    strobe_n = 1'b1;
    settle();
  endtask

  task automatic write_reg(input logic [7:0] a, input logic [7:0] v);
    strobe_lo(1'b0, 1'b0, a); strobe_hi();
    strobe_lo(1'b0, 1'b1, v); strobe_hi();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R1, R6: reset state shows live sample
    expect_both(1'b1, 8'h77, 1'b1, 8'h77, "R1");
    sample_in = 8'h19;
    @(negedge clk);
    expect_both(1'b1, 8'h19, 1'b1, 8'h19, "R6");

    // R10: read strobe while not armed
    strobe_lo(1'b1, 1'b1, 8'h00);
    expect_both(1'b1, 8'h19, 1'b1, 8'h19, "R10");
    strobe_hi();

    // R7: host phases release the bus
    strobe_lo(1'b0, 1'b0, 8'h05);
    expect_both(1'b0, 8'h00, 1'b0, 8'h00, "R7 address");
    strobe_hi();
    strobe_lo(1'b0, 1'b1, 8'hC1);
    expect_both(1'b0, 8'h00, 1'b0, 8'h00, "R7 data");
    strobe_hi();
    expect_both(1'b1, 8'h19, 1'b1, 8'h19, "R7 resume");

    write_reg(8'h25, 8'h3C);
    write_reg(8'h03, 8'h5A);

    // R2, R3, R5: read back 0x05 via flagged 0x15
    strobe_lo(1'b0, 1'b0, 8'h15); strobe_hi();
    strobe_lo(1'b1, 1'b1, 8'h00);
    expect_both(1'b1, 8'hC1, 1'b1, 8'hC1, "R5");
    strobe_hi();
    // R9: return policy
    expect_both(1'b1, 8'h19, 1'b1, 8'hC1, "R9 after rise");
    // R11: ignored strobe keeps bus driven; hold unit returns on this fall
    strobe_lo(1'b1, 1'b0, 8'hFF);
    expect_both(1'b1, 8'h19, 1'b1, 8'h19, "R11 R9 next fall");
    strobe_hi();
    // R11: arming survives the ignored strobe
    strobe_lo(1'b1, 1'b1, 8'h00);
    expect_both(1'b1, 8'hC1, 1'b1, 8'hC1, "R11 still armed");
    strobe_hi();

    // R2: upper half register
    strobe_lo(1'b0, 1'b0, 8'h35); strobe_hi();
    strobe_lo(1'b1, 1'b1, 8'h00);
    expect_both(1'b1, 8'h3C, 1'b1, 8'h3C, "R2");
    strobe_hi();

    // R4: flagged write changes nothing
    strobe_lo(1'b0, 1'b0, 8'h13); strobe_hi();
    strobe_lo(1'b0, 1'b1, 8'hEE); strobe_hi();
    strobe_lo(1'b1, 1'b1, 8'h00);
    expect_both(1'b1, 8'h5A, 1'b1, 8'h5A, "R4");
    strobe_hi();

    // R8: output enable high tri-states everything
    sample_in = 8'h42;
    oe_n = 1'b1;
    settle();
    expect_both(1'b0, 8'h00, 1'b0, 8'h00, "R8 idle");
    strobe_lo(1'b1, 1'b1, 8'h00);
    expect_both(1'b0, 8'h00, 1'b0, 8'h00, "R8 read");
    strobe_hi();
    oe_n = 1'b0;
    settle();
    expect_both(1'b1, 8'h42, 1'b1, 8'h5A, "R8 R9 enable again");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule